// File: doc/BRIEF.md
# Configuration Register SPI Slave with Status Reporting

This block is the serial front door to a bank of byte-wide configuration registers. A host drives an SPI link (mode 0, MSB first) and frames each access with a header byte. The header carries a direction flag, a burst flag and a six-bit register address. Later bytes in the frame carry register data. While the host clocks in a header, the block clocks out a status byte. That byte reports whether the device is ready, the code of the main state machine, and a FIFO level. On a read the level is the receive FIFO fill, and on a write it is the transmit FIFO free space.

The link pins are brought into the system clock domain through synchronizers, and edges of the serial clock are detected there. The register contents are presented in parallel on `cfg_o` for the rest of the chip to use. The state code and the FIFO counts come from logic outside this block and are only reported here.

Top module: `spi_cfg_slave`

## Requirements
- R1: Header byte layout: bit 7 is the direction (1 = read, 0 = write), bit 6 is the burst flag, and bits 5:0 are the register address. Without the burst flag, exactly one data byte follows, and the next byte in the same frame is a new header.
- R2: A write data byte is stored in the addressed register and appears on `cfg_o[8*a +: 8]` for address a.
- R3: In a read, the data byte slot returns the addressed register's contents, MSB first.
- R4: The byte returned in every header slot is a status byte. Bit 7 is the inverse of `ready_i`, and bits 6:4 equal `state_i`.
- R5: Status bits 3:0 give `rx_count_i` when the header's direction bit is 1 and `tx_free_i` when it is 0. Any count of 15 or more reads as 15.
- R6: Every data slot of a write returns the status byte, with bits 3:0 taken from the transmit free count.
- R7: With the burst flag set, the address advances by one after each data byte, for reads and writes, until chip select deasserts.
- R8: Registers exist at 0x00 to 0x2E. Writes beyond 0x2E leave every register unchanged, and reads beyond it return 0x00. A burst that runs past 0x3F does not wrap back to 0x00.
- R9: Raising chip select in the middle of a byte drops that byte with no register change. The first byte of the next frame is a header.
- R10: Status bit 7 is on the data output before the first rising serial clock edge of a frame.
- R11: After reset every register is 0x00, and the data output is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host, idles low |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in from host |
| miso_o | output | 1 | Serial data out to host |
| ready_i | input | 1 | Power and clock stable flag |
| state_i | input | 3 | Main state code to report |
| rx_count_i | input | CNT_W | Bytes held in receive FIFO |
| tx_free_i | input | CNT_W | Free bytes in transmit FIFO |
| cfg_o | output | 8*NUM_REGS | All register contents, register a at bits 8a+7:8a |

## Verification
The hardest case to reach is the burst address counter leaving the implemented range and then passing the top of the six-bit address space. There it must keep returning zeros and must not wrap onto register 0x00. The bench first writes a nonzero value into register 0x00. It then opens a burst read at 0x3E and clocks three data slots, so the third slot would expose a wrap. A second hard case is the mid-byte abort. The bench raises chip select after four bits of a data byte and then reads the target back in a fresh frame.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W = 6;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic {PH_HDR, PH_DATA} phase_e;

  typedef struct packed {
    logic              rd;
    logic              burst;
    logic [ADDR_W-1:0] addr;
  } hdr_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sel_o,
  output logic sel_start_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic mosi_o
);
  logic [STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic sclk_d, cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[STAGES-2:0], sclk_i};
      cs_s   <= {cs_s[STAGES-2:0], cs_ni};
      mosi_s <= {mosi_s[STAGES-2:0], mosi_i};
      sclk_d <= sclk_s[STAGES-1];
      cs_d   <= cs_s[STAGES-1];
    end
  end

  assign sel_o       = !cs_s[STAGES-1];
  assign sel_start_o = sel_o && cs_d;
  assign sclk_rise_o = sel_o && sclk_s[STAGES-1] && !sclk_d;
  assign sclk_fall_o = sel_o && !sclk_s[STAGES-1] && sclk_d;
  assign mosi_o      = mosi_s[STAGES-1];
endmodule

// File: rtl/spi_cfg_status.sv
module spi_cfg_status
  import spi_cfg_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              ready_i,
  input  logic [2:0]        state_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [CNT_W-1:0]  tx_free_i,
  output logic [BYTE_W-1:0] stat_rd_o,
  output logic [BYTE_W-1:0] stat_wr_o
);
  localparam int SAT = (1 << NIB_W) - 1;

  function automatic logic [NIB_W-1:0] sat_nib(input logic [CNT_W-1:0] v);
    return (int'(v) >= SAT) ? NIB_W'(SAT) : v[NIB_W-1:0];
  endfunction

  assign stat_rd_o = {!ready_i, state_i, sat_nib(rx_count_i)};
  assign stat_wr_o = {!ready_i, state_i, sat_nib(tx_free_i)};
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 47
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  logic [BYTE_W-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_en_i && int'(wr_addr_i) == g) mem_q[g] <= wr_data_i;
    end
    assign cfg_o[g*BYTE_W +: BYTE_W] = mem_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(rd_addr_i) == i) rd_data_o = mem_q[i];
  end
endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 47
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sel_start_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] stat_rd_i,
  input  logic [BYTE_W-1:0] stat_wr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              miso_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  phase_e            phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q, out_q, sh_nxt;
  hdr_t              hdr_q, hdr_nxt;
  logic              past_q, miso_q;
  logic              byte_end, wrap;
  logic [ADDR_W-1:0] addr_inc;

  assign sh_nxt    = {sh_q[BYTE_W-2:0], mosi_i};
  assign hdr_nxt   = hdr_t'(sh_nxt);
  assign byte_end  = sel_i && sclk_rise_i && (bit_q == BIT_W'(BYTE_W-1));
  assign addr_inc  = hdr_q.addr + 1'b1;
  assign wrap      = &hdr_q.addr;
  // header slot: fetch at incoming address; data slot: prefetch next
  assign rd_addr_o = (phase_q == PH_HDR) ? hdr_nxt.addr : addr_inc;
  assign wr_en_o   = byte_end && (phase_q == PH_DATA) && !hdr_q.rd && !past_q
                     && (int'(hdr_q.addr) < NUM_REGS);
  assign wr_addr_o = hdr_q.addr;
  assign wr_data_o = sh_nxt;
  assign miso_o    = miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HDR;
      bit_q   <= '0;
      sh_q    <= '0;
      out_q   <= '0;
      hdr_q   <= '0;
      past_q  <= 1'b0;
      miso_q  <= 1'b0;
    end else if (!sel_i) begin
      phase_q <= PH_HDR;
      bit_q   <= '0;
      miso_q  <= 1'b0;
    end else if (sel_start_i) begin
      phase_q <= PH_HDR;
      bit_q   <= '0;
      out_q   <= stat_wr_i;
      miso_q  <= stat_wr_i[BYTE_W-1];
    end else if (sclk_rise_i) begin
      sh_q  <= sh_nxt;
      bit_q <= bit_q + 1'b1;
      // direction bit is first in; nibble leaves after it is known
      if (phase_q == PH_HDR && bit_q == '0)
        out_q[NIB_W-1:0] <= mosi_i ? stat_rd_i[NIB_W-1:0] : stat_wr_i[NIB_W-1:0];
      if (byte_end) begin
        if (phase_q == PH_HDR) begin
          hdr_q   <= hdr_nxt;
          past_q  <= 1'b0;
          phase_q <= PH_DATA;
          out_q   <= hdr_nxt.rd ? rd_data_i : stat_wr_i;
        end else if (hdr_q.burst) begin
          hdr_q.addr <= addr_inc;
          past_q     <= past_q | wrap;
          if (!hdr_q.rd)            out_q <= stat_wr_i;
          else if (past_q || wrap)  out_q <= '0;
          else                      out_q <= rd_data_i;
        end else begin
          phase_q <= PH_HDR;
          out_q   <= stat_wr_i;
        end
      end
    end else if (sclk_fall_i) begin
      miso_q <= out_q[BIT_W'(BYTE_W-1) - bit_q];
    end
  end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 47,
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       cs_ni,
  input  logic                       mosi_i,
  output logic                       miso_o,
  input  logic                       ready_i,
  input  logic [2:0]                 state_i,
  input  logic [CNT_W-1:0]           rx_count_i,
  input  logic [CNT_W-1:0]           tx_free_i,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  logic              sel, sel_start, sclk_rise, sclk_fall, mosi_s;
  logic [BYTE_W-1:0] stat_rd, stat_wr, rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en;

  spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .sel_o(sel), .sel_start_o(sel_start), .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall), .mosi_o(mosi_s)
  );

  spi_cfg_status #(.CNT_W(CNT_W)) u_status (
    .ready_i, .state_i, .rx_count_i, .tx_free_i,
    .stat_rd_o(stat_rd), .stat_wr_o(stat_wr)
  );

  spi_cfg_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk_i, .rst_ni, .sel_i(sel), .sel_start_i(sel_start),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .mosi_i(mosi_s),
    .stat_rd_i(stat_rd), .stat_wr_i(stat_wr), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .miso_o
  );

  spi_cfg_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cfg_o
  );
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk #(
  parameter int NUM_REGS = 47
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sel,
  input logic                  sel_start,
  input logic                  wr_en,
  input logic [5:0]            wr_addr,
  input logic [7:0]            wr_data,
  input logic [NUM_REGS*8-1:0] cfg_o,
  input logic                  miso_o,
  input logic                  ready_i
);
  logic       wr_seen_q;
  logic [5:0] wr_addr_q;
  logic [7:0] wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_seen_q <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_seen_q <= wr_en;
      wr_addr_q <= wr_addr;
      wr_data_q <= wr_data;
    end
  end

  assert_wr_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> int'(wr_addr) < NUM_REGS);

  assert_wr_needs_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> !wr_en);

  assert_wr_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_seen_q |-> cfg_o[int'(wr_addr_q)*8 +: 8] == wr_data_q);

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(cfg_o));

  assert_idle_miso_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> !miso_o);

  assert_first_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_start |=> miso_o == !$past(ready_i));
endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i, .rst_ni, .sel, .sel_start, .wr_en, .wr_addr, .wr_data,
  .cfg_o, .miso_o, .ready_i
);

// File: tb/spi_cfg_slave_test.sv
module spi_cfg_slave_test;
  localparam int NUM_REGS = 47;
  localparam int CNT_W    = 7;
  localparam int HALF     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic ready = 1'b1;
  logic [2:0] state = 3'd0;
  logic [CNT_W-1:0] rx_cnt = '0, tx_free = '0;
  logic [NUM_REGS*8-1:0] cfg;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx_b [16];
  logic [7:0] rx_b [16];
  logic [7:0] mdl [NUM_REGS];

  always #2.5 clk = ~clk;

  spi_cfg_slave #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .ready_i(ready), .state_i(state), .rx_count_i(rx_cnt),
    .tx_free_i(tx_free), .cfg_o(cfg)
  );

  function automatic logic [3:0] sat(input logic [CNT_W-1:0] v);
    return (v >= 15) ? 4'hF : v[3:0];
  endfunction

  function automatic logic [7:0] st(input logic rd);
    return {~ready, state, rd ? sat(rx_cnt) : sat(tx_free)};
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int a = 0; a < NUM_REGS; a++) chk(req, $sformatf("reg %02h", a), cfg[a*8 +: 8], mdl[a]);
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] b, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      half_wait();
      r[i] = miso;
      sclk = 1'b1;
      half_wait();
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input int n);
    cs_n = 1'b0;
    for (int i = 0; i < n; i++) shift_bits(tx_b[i], 8, rx_b[i]);
    half_wait();
    cs_n = 1'b1;
    half_wait();
    half_wait();
  endtask

  task automatic t_reset();
    chk("R11", "miso after reset", {7'd0, miso}, 8'h00);
    chk_regs("R11");
  endtask

  task automatic t_single_write();
    ready = 1'b1; state = 3'b001; tx_free = 7'd9; rx_cnt = 7'd2;
    tx_b[0] = 8'h05; tx_b[1] = 8'hA5;
    xfer(2);
    mdl[5] = 8'hA5;
    chk("R4", "write header status", rx_b[0], st(1'b0));
    chk("R6", "write data slot status", rx_b[1], st(1'b0));
    chk("R2", "reg 05 written", cfg[5*8 +: 8], 8'hA5);
  endtask

  task automatic t_single_read();
    state = 3'b010; rx_cnt = 7'd3; tx_free = 7'd11;
    tx_b[0] = 8'h85; tx_b[1] = 8'h00; tx_b[2] = 8'h85; tx_b[3] = 8'h00;
    xfer(4);
    chk("R5", "read header nibble rx", rx_b[0], st(1'b1));
    chk("R3", "read data slot", rx_b[1], 8'hA5);
    chk("R1", "second header in frame", rx_b[2], st(1'b1));
    chk("R1", "second read data", rx_b[3], 8'hA5);
  endtask

  task automatic t_saturate();
    rx_cnt = 7'd40; tx_b[0] = 8'h85; tx_b[1] = 8'h00;
    xfer(2);
    chk("R5", "rx 40 saturates", rx_b[0][3:0], 8'h0F);
    tx_free = 7'd15; tx_b[0] = 8'h06; tx_b[1] = 8'h11;
    xfer(2);
    mdl[6] = 8'h11;
    chk("R5", "tx 15 reads 15", rx_b[0][3:0], 8'h0F);
    tx_free = 7'd14; tx_b[0] = 8'h06; tx_b[1] = 8'h12;
    xfer(2);
    mdl[6] = 8'h12;
    chk("R5", "tx 14 reads 14", rx_b[0][3:0], 8'h0E);
    chk("R6", "data slot tx 14", rx_b[1], st(1'b0));
  endtask

  task automatic t_burst();
    tx_free = 7'd5; rx_cnt = 7'd1;
    tx_b[0] = 8'h6C; tx_b[1] = 8'h11; tx_b[2] = 8'h22; tx_b[3] = 8'h33; tx_b[4] = 8'h44;
    xfer(5);
    mdl[8'h2C] = 8'h11; mdl[8'h2D] = 8'h22; mdl[8'h2E] = 8'h33;
    chk("R7", "burst write 2C", cfg[8'h2C*8 +: 8], 8'h11);
    chk("R7", "burst write 2E", cfg[8'h2E*8 +: 8], 8'h33);
    chk("R6", "burst data slot status", rx_b[4], st(1'b0));
    chk_regs("R8");
    tx_b[0] = 8'hED;
    for (int i = 1; i < 5; i++) tx_b[i] = 8'hFF;
    xfer(5);
    chk("R7", "burst read 2D", rx_b[1], 8'h22);
    chk("R7", "burst read 2E", rx_b[2], 8'h33);
    chk("R8", "burst read 2F", rx_b[3], 8'h00);
    chk("R8", "burst read 30", rx_b[4], 8'h00);
    tx_b[0] = 8'h30; tx_b[1] = 8'h77;
    xfer(2);
    chk_regs("R8");
    tx_b[0] = 8'hBF; tx_b[1] = 8'hFF;
    xfer(2);
    chk("R8", "read 3F", rx_b[1], 8'h00);
  endtask

  task automatic t_wrap();
    tx_b[0] = 8'h00; tx_b[1] = 8'h5A;
    xfer(2);
    mdl[0] = 8'h5A;
    chk("R2", "reg 00 written", cfg[7:0], 8'h5A);
    tx_b[0] = 8'hFE; tx_b[1] = 8'hFF; tx_b[2] = 8'hFF; tx_b[3] = 8'hFF;
    xfer(4);
    chk("R8", "burst 3E", rx_b[1], 8'h00);
    chk("R8", "burst 3F", rx_b[2], 8'h00);
    chk("R8", "burst past 3F no wrap", rx_b[3], 8'h00);
  endtask

  task automatic t_status();
    ready = 1'b0; state = 3'b110; tx_free = 7'd0;
    tx_b[0] = 8'h07; tx_b[1] = 8'h3C;
    xfer(2);
    mdl[7] = 8'h3C;
    chk("R10", "first bit not ready", {7'd0, rx_b[0][7]}, 8'h01);
    chk("R4", "status overflow code", rx_b[0], st(1'b0));
    ready = 1'b1; state = 3'b111; rx_cnt = 7'd7;
    tx_b[0] = 8'h87; tx_b[1] = 8'h00;
    xfer(2);
    chk("R10", "first bit ready", {7'd0, rx_b[0][7]}, 8'h00);
    chk("R4", "status underflow code", rx_b[0], st(1'b1));
    chk("R3", "read back 07", rx_b[1], 8'h3C);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    state = 3'b000; rx_cnt = 7'd4;
    cs_n = 1'b0;
    shift_bits(8'h05, 8, r);
    shift_bits(8'h3C, 4, r);
    half_wait();
    cs_n = 1'b1;
    half_wait();
    half_wait();
    chk("R9", "partial write dropped", cfg[5*8 +: 8], 8'hA5);
    tx_b[0] = 8'h85; tx_b[1] = 8'h00;
    xfer(2);
    chk("R9", "next frame header status", rx_b[0], st(1'b1));
    chk("R9", "next frame read", rx_b[1], 8'hA5);
    chk_regs("R9");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int a = 0; a < NUM_REGS; a++) mdl[a] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_write();
    t_single_read();
    t_saturate();
    t_burst();
    t_wrap();
    t_status();
    t_abort();
    finish_run();
  end
endmodule